// File: doc/BRIEF.md
# SPI controller with status flags

A byte-wide serial peripheral interface controller that works either as bus master or as slave. Software reaches it through a small register port with three addresses: a control register, a status register and a data register. As master it divides the peripheral clock into SCK with a power-of-two rate code. It moves one byte per transfer, most significant bit first, in clock mode 0: the line changes on the falling edge and is sampled on the rising edge. As slave it follows an external SCK while its active-low select input is held low.

Four status flags report the outcome of a transfer. Transfer-done, write-collision and mode-fault are cleared by a two-step sequence: a status read that sees any of them set, then any access to the data register. The slave-select-error flag is raised when a slave byte is cut short. It stays set until software turns the controller off. A master that finds its select input pulled low by another device gives up the bus. It then falls back to slave mode.

Top module: `spi_unit`

## Requirements
- R1: As master with rate code r (control bits 4:2) from 1 to 6, SCK has a period of 4<<(r-1) clock cycles during a transfer, and it idles low.
- R2: As master with rate code 0 or 7, a data write starts no transfer: SCK stays low and no status flag is raised.
- R3: A master transfer shifts the written byte out on MOSI MSB first, changing on falling SCK, and samples MISO on rising SCK. After 8 bits, status bit 7 (transfer done) is set and the received byte reads back at the data address.
- R4: Status layout: bit 7 transfer done, bit 6 write collision, bit 5 slave-select error, bit 4 mode fault. Bits 3:0 read 0, and writes to the status address have no effect.
- R5: A data write while a transfer is in progress sets status bit 6. The written byte is dropped, and the byte in flight completes unchanged.
- R6: A status read that sees bit 7, 6 or 4 set, followed by a read or write of the data register, clears those three bits. A data access with no such status read before it leaves them set.
- R7: As slave, with the select input low, the block samples its serial input on rising SCK and shifts its serial output on falling SCK, MSB first. After 8 rising edges it sets status bit 7, and the received byte reads back at the data address. The serial output is enabled only while the select input is low.
- R8: As slave, raising the select input partway through a byte sets status bit 5 and drops the partial byte. Only clearing the enable bit clears status bit 5; the clearing sequence does not.
- R9: An enabled master whose select input goes low sets status bit 4, clears the master bit (control bit 1), aborts the transfer without setting bit 7, and stops driving SCK and MOSI.
- R10: Address 0 is control (bit 0 enable, bit 1 master, bits 4:2 rate; bits 7:5 read 0), address 1 is status and address 2 is data. Everything resets to 0.
- R11: With the enable bit clear, data writes start nothing and no serial output is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| sck_o | output | 1 | SCK driven as master |
| sck_oe_o | output | 1 | SCK output enable |
| mosi_o | output | 1 | Serial data out as master |
| mosi_oe_o | output | 1 | Master data output enable |
| miso_i | input | 1 | Serial data in as master |
| sck_i | input | 1 | SCK received as slave |
| mosi_i | input | 1 | Serial data in as slave |
| miso_o | output | 1 | Serial data out as slave |
| miso_oe_o | output | 1 | Slave data output enable |
| ss_ni | input | 1 | Select input, active low |

## Verification
The bench goes after the boundaries between the flag rules. A write collision must leave the in-flight byte intact, so a design that loaded the late write would put the wrong bits on MOSI. A data read with no status read before it must not clear the flags; a design that cleared on any data access would lose the done flag. The slave-select error must survive the clearing sequence and go away only on disable. The invalid rate codes 0 and 7 must keep SCK silent, where a careless divider would toggle at the fastest rate or stall halfway through a byte. A mode fault mid-transfer must release SCK and MOSI and leave the done flag clear.

// File: rtl/spi_unit_pkg.sv
package spi_unit_pkg;
  localparam int RATE_W = 3;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              master;
    logic              en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  function automatic logic rate_valid(input logic [RATE_W-1:0] r);
    return (r != '0) && (r != '1);
  endfunction
endpackage

// File: rtl/spi_unit_sync.sv
module spi_unit_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[s] <= RST_VAL;
          else         stg_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[s] <= RST_VAL;
          else         stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_unit_clkgen.sv
module spi_unit_clkgen #(
  parameter int RATE_W = 3,
  localparam int CNT_W = (1 << RATE_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  // half SCK period = 2^rate clock cycles
  assign lim    = CNT_W'((1 << rate_i) - 1);
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0))
    else $error("assert_div_restart_R1");
endmodule

// File: rtl/spi_unit_engine.sv
module spi_unit_engine #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              master_i,
  input  logic              rate_ok_i,
  input  logic              abort_i,
  input  logic              tick_i,
  input  logic              miso_i,
  input  logic              sck_s_i,
  input  logic              mosi_s_i,
  input  logic              ss_n_s_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic              run_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              sserr_o,
  output logic [DATA_W-1:0] rx_o,
  output logic              tx_bit_o,
  output logic              sck_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] tx_q, rx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              m_busy_q, sck_q, sck_d_q, done_q, sserr_q;
  logic              m_active, s_active, sck_rise, sck_fall;

  assign m_active = en_i && master_i && rate_ok_i && !abort_i;
  assign s_active = en_i && !master_i;
  assign sck_rise = sck_s_i && !sck_d_q;
  assign sck_fall = !sck_s_i && sck_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q     <= '0;
      rx_q     <= '0;
      cnt_q    <= '0;
      m_busy_q <= 1'b0;
      sck_q    <= 1'b0;
      sck_d_q  <= 1'b0;
      done_q   <= 1'b0;
      sserr_q  <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      sserr_q <= 1'b0;
      sck_d_q <= sck_s_i;
      if (load_i) begin
        tx_q  <= load_data_i;
        cnt_q <= '0;
        if (master_i) begin
          m_busy_q <= 1'b1;
          sck_q    <= 1'b0;
        end
      end else if (m_busy_q) begin
        if (!m_active) begin
          m_busy_q <= 1'b0;
          sck_q    <= 1'b0;
          cnt_q    <= '0;
        end else if (tick_i) begin
          sck_q <= ~sck_q;
          if (!sck_q) begin
            rx_q <= {rx_q[DATA_W-2:0], miso_i};
          end else begin
            tx_q <= {tx_q[DATA_W-2:0], 1'b0};
            if (cnt_q == LAST) begin
              m_busy_q <= 1'b0;
              done_q   <= 1'b1;
              cnt_q    <= '0;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
      end else if (s_active) begin
        if (ss_n_s_i) begin
          // deselect mid-byte: drop partial byte
          if (cnt_q != '0) sserr_q <= 1'b1;
          cnt_q <= '0;
        end else if (sck_rise) begin
          rx_q <= {rx_q[DATA_W-2:0], mosi_s_i};
          if (cnt_q == LAST) begin
            done_q <= 1'b1;
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end else if (sck_fall && cnt_q != '0) begin
          tx_q <= {tx_q[DATA_W-2:0], 1'b0};
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign run_o    = m_busy_q;
  assign busy_o   = m_busy_q || (s_active && !ss_n_s_i && cnt_q != '0);
  assign done_o   = done_q;
  assign sserr_o  = sserr_q;
  assign rx_o     = rx_q;
  assign tx_bit_o = tx_q[DATA_W-1];
  assign sck_o    = sck_q;

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !load_i)
    else $error("assert_no_load_busy_R5");

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    !m_active |=> !sck_q)
    else $error("assert_sck_idle_R2");

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(m_busy_q) && $past(m_active)) |-> done_q)
    else $error("assert_master_done_R3");

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    sserr_q |-> $past(!master_i))
    else $error("assert_sserr_slave_R8");
endmodule

// File: rtl/spi_unit_status.sv
module spi_unit_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic done_i,
  input  logic wcol_set_i,
  input  logic sserr_set_i,
  input  logic modf_set_i,
  input  logic stat_rd_i,
  input  logic data_acc_i,
  output logic spif_o,
  output logic wcol_o,
  output logic sserr_o,
  output logic modf_o
);
  logic spif_q, wcol_q, sserr_q, modf_q, armed_q;
  logic clr;

  assign clr = data_acc_i && armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spif_q  <= 1'b0;
      wcol_q  <= 1'b0;
      sserr_q <= 1'b0;
      modf_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (stat_rd_i && (spif_q || wcol_q || modf_q)) armed_q <= 1'b1;
      else if (data_acc_i)                           armed_q <= 1'b0;
      // hardware set wins over the clearing access
      spif_q  <= done_i     || (spif_q && !clr);
      wcol_q  <= wcol_set_i || (wcol_q && !clr);
      modf_q  <= modf_set_i || (modf_q && !clr);
      sserr_q <= en_i && (sserr_set_i || sserr_q);
    end
  end

  assign spif_o  = spif_q;
  assign wcol_o  = wcol_q;
  assign sserr_o = sserr_q;
  assign modf_o  = modf_q;

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> spif_q)
    else $error("assert_spif_set_R3");

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !done_i && !wcol_set_i && !modf_set_i) |=> (!spif_q && !wcol_q && !modf_q))
    else $error("assert_clear_seq_R6");

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sserr_q && en_i) |=> sserr_q)
    else $error("assert_sserr_sticky_R8");

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sserr_q)
    else $error("assert_sserr_disable_R8");
endmodule

// File: rtl/spi_unit.sv
module spi_unit
  import spi_unit_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sck_o,
  output logic              sck_oe_o,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  input  logic              miso_i,
  input  logic              sck_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  input  logic              ss_ni
);
  localparam int FLAG_N = 4;

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] rdbuf_q;
  logic              ss_n_s, sck_s, mosi_s;
  logic              ctrl_wr, stat_rd, data_wr, data_rd;
  logic              rate_ok, busy, load, wcol_set, modf_set;
  logic              run, tick, done, sserr_set, tx_bit, sck_q;
  logic [DATA_W-1:0] rx;
  logic              spif, wcol, sserr, modf;
  logic              master_on, slave_sel;
  logic              unused_wdata;

  spi_unit_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ss_ni, sck_i, mosi_i}),
    .q_o   ({ss_n_s, sck_s, mosi_s})
  );

  assign ctrl_wr = sel_i &&  wr_i && (addr_i == REG_CTRL);
  assign stat_rd = sel_i && !wr_i && (addr_i == REG_STAT);
  assign data_wr = sel_i &&  wr_i && (addr_i == REG_DATA);
  assign data_rd = sel_i && !wr_i && (addr_i == REG_DATA);

  assign rate_ok  = rate_valid(ctrl_q.rate);
  assign modf_set = ctrl_q.en && ctrl_q.master && !ss_n_s;
  assign wcol_set = data_wr && ctrl_q.en && busy;
  assign load     = data_wr && ctrl_q.en && !busy && (rate_ok || !ctrl_q.master);

  assign unused_wdata = ^wdata_i[DATA_W-1:CTRL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (modf_set) ctrl_q.master <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdbuf_q <= '0;
    else if (done) rdbuf_q <= rx;
  end

  spi_unit_clkgen #(
    .RATE_W(RATE_W)
  ) u_clkgen (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .rate_i(ctrl_q.rate),
    .tick_o(tick)
  );

  spi_unit_engine #(
    .DATA_W(DATA_W)
  ) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ctrl_q.en),
    .master_i   (ctrl_q.master),
    .rate_ok_i  (rate_ok),
    .abort_i    (modf_set),
    .tick_i     (tick),
    .miso_i     (miso_i),
    .sck_s_i    (sck_s),
    .mosi_s_i   (mosi_s),
    .ss_n_s_i   (ss_n_s),
    .load_i     (load),
    .load_data_i(wdata_i),
    .run_o      (run),
    .busy_o     (busy),
    .done_o     (done),
    .sserr_o    (sserr_set),
    .rx_o       (rx),
    .tx_bit_o   (tx_bit),
    .sck_o      (sck_q)
  );

  spi_unit_status u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ctrl_q.en),
    .done_i     (done),
    .wcol_set_i (wcol_set),
    .sserr_set_i(sserr_set),
    .modf_set_i (modf_set),
    .stat_rd_i  (stat_rd),
    .data_acc_i (data_wr || data_rd),
    .spif_o     (spif),
    .wcol_o     (wcol),
    .sserr_o    (sserr),
    .modf_o     (modf)
  );

  always_comb begin
    unique case (addr_i)
      REG_CTRL: rdata_o = DATA_W'(ctrl_q);
      REG_STAT: rdata_o = {spif, wcol, sserr, modf, {(DATA_W-FLAG_N){1'b0}}};
      REG_DATA: rdata_o = rdbuf_q;
      default:  rdata_o = '0;
    endcase
  end

  assign master_on = ctrl_q.en && ctrl_q.master;
  assign slave_sel = ctrl_q.en && !ctrl_q.master && !ss_n_s;

  assign sck_o     = master_on && sck_q;
  assign sck_oe_o  = master_on;
  assign mosi_o    = master_on && tx_bit;
  assign mosi_oe_o = master_on;
  assign miso_o    = slave_sel && tx_bit;
  assign miso_oe_o = slave_sel;

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(modf) |-> !ctrl_q.master)
    else $error("assert_modf_drops_master_R9");

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd |-> (rdata_o[DATA_W-FLAG_N-1:0] == '0))
    else $error("assert_stat_reserved_R4");

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.en |-> (!sck_oe_o && !mosi_oe_o && !miso_oe_o))
    else $error("assert_off_quiet_R11");
endmodule

// File: tb/spi_unit_test.sv
module spi_unit_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_i;
  logic       sck_i = 1'b0, mosi_i = 1'b0, miso_o, miso_oe, ss_n = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // bench-side slave for master tests
  logic [7:0] peer_byte = '0;
  logic [7:0] peer_rx;
  int         peer_idx;
  logic       peer_rst = 1'b0;
  time        t_prev = 0, t_last = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_unit uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .sel_i    (sel),
    .wr_i     (wr),
    .addr_i   (addr),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .sck_o    (sck_o),
    .sck_oe_o (sck_oe),
    .mosi_o   (mosi_o),
    .mosi_oe_o(mosi_oe),
    .miso_i   (miso_i),
    .sck_i    (sck_i),
    .mosi_i   (mosi_i),
    .miso_o   (miso_o),
    .miso_oe_o(miso_oe),
    .ss_ni    (ss_n)
  );

  assign miso_i = (peer_idx < 8) ? peer_byte[7-peer_idx] : 1'b0;

  always @(negedge sck_o or posedge peer_rst) begin
    if (peer_rst) peer_idx <= 0;
    else          peer_idx <= peer_idx + 1;
  end

  always @(posedge sck_o) begin
    peer_rx <= {peer_rx[6:0], mosi_o};
    t_prev  = t_last;
    t_last  = $time;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic peer_load(input logic [7:0] b);
    peer_byte = b;
    peer_rst = 1'b1;
    #1 peer_rst = 1'b0;
  endtask

  task automatic test_reset();
    logic [7:0] v;
    bus_read(2'd0, v); check("R10 reset control", v, 8'h00);
    bus_read(2'd1, v); check("R10 reset status", v, 8'h00);
    bus_read(2'd2, v); check("R10 reset data", v, 8'h00);
    check("R11 reset sck_oe", sck_oe, 0);
    check("R11 reset miso_oe", miso_oe, 0);
  endtask

  task automatic test_ctrl_map();
    logic [7:0] v;
    bus_write(2'd0, 8'hFE);
    bus_read(2'd0, v); check("R10 control readback masks 7:5", v, 8'h1E);
    bus_write(2'd0, 8'h00);
    bus_read(2'd3, v); check("R10 unused address reads 0", v, 8'h00);
  endtask

  task automatic test_disabled();
    logic [7:0] v;
    int hi = 0;
    bus_write(2'd0, 8'h06);
    bus_write(2'd2, 8'h5A);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (sck_o || sck_oe || mosi_oe || miso_oe) hi++;
    end
    check("R11 disabled: no serial activity", hi, 0);
    bus_read(2'd1, v); check("R11 disabled: status", v, 8'h00);
    bus_write(2'd0, 8'h00);
  endtask

  task automatic test_master(input int rate, input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] v;
    int half = 1 << rate;
    peer_load(rx);
    bus_write(2'd0, 8'(3 | (rate << 2)));
    bus_write(2'd2, tx);
    wait_clk(16 * half + 8);
    check($sformatf("R1 sck period rate %0d", rate), int'((t_last - t_prev) / CLK_PERIOD), 4 << (rate - 1));
    check("R1 sck idles low after transfer", sck_o, 0);
    check("R3 mosi bits seen by peer", peer_rx, tx);
    bus_read(2'd1, v); check("R3 done flag set", v, 8'h80);
    bus_read(2'd2, v); check("R3 received byte", v, rx);
    bus_read(2'd1, v); check("R6 flags cleared by sequence", v, 8'h00);
  endtask

  task automatic test_invalid_rate(input logic [7:0] ctrl);
    logic [7:0] v;
    int hi = 0;
    bus_write(2'd0, ctrl);
    bus_write(2'd2, 8'hAA);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (sck_o) hi++;
    end
    check("R2 invalid rate keeps sck low", hi, 0);
    bus_read(2'd1, v); check("R2 invalid rate raises no flag", v, 8'h00);
    bus_write(2'd0, 8'h00);
  endtask

  task automatic test_wcol();
    logic [7:0] v;
    peer_load(8'h69);
    bus_write(2'd0, 8'h0B);
    bus_write(2'd2, 8'hC3);
    wait_clk(20);
    bus_write(2'd2, 8'h55);
    bus_read(2'd1, v); check("R5 collision flag during transfer", v, 8'h40);
    wait_clk(16 * 4 + 8);
    check("R5 in-flight byte unchanged", peer_rx, 8'hC3);
    bus_read(2'd1, v); check("R4 done and collision bits", v, 8'hC0);
    bus_read(2'd2, v); check("R5 received byte", v, 8'h69);
    bus_read(2'd1, v); check("R6 collision cleared", v, 8'h00);
    bus_write(2'd0, 8'h00);
  endtask

  task automatic test_no_premature_clear();
    logic [7:0] v;
    peer_load(8'h0F);
    bus_write(2'd0, 8'h07);
    bus_write(2'd2, 8'hF0);
    wait_clk(16 * 2 + 8);
    bus_write(2'd1, 8'h00);
    bus_read(2'd2, v); check("R6 data read value", v, 8'h0F);
    bus_read(2'd1, v); check("R6 R4 flag kept without status read first", v, 8'h80);
    bus_read(2'd2, v);
    bus_read(2'd1, v); check("R6 cleared after proper sequence", v, 8'h00);
    bus_write(2'd0, 8'h00);
  endtask

  task automatic test_modf();
    logic [7:0] v;
    peer_load(8'h00);
    bus_write(2'd0, 8'h0B);
    bus_write(2'd2, 8'hE7);
    wait_clk(20);
    ss_n = 1'b0;
    wait_clk(6);
    check("R9 sck released", sck_oe, 0);
    check("R9 mosi released", mosi_oe, 0);
    bus_read(2'd1, v); check("R9 mode fault only", v, 8'h10);
    bus_read(2'd0, v); check("R9 master bit cleared", v, 8'h09);
    wait_clk(80);
    bus_read(2'd1, v); check("R9 aborted transfer sets no done", v, 8'h10);
    ss_n = 1'b1;
    bus_read(2'd2, v);
    bus_read(2'd1, v); check("R6 mode fault cleared", v, 8'h00);
    bus_write(2'd0, 8'h00);
  endtask

  task automatic slave_bits(input logic [7:0] b, input int n, output logic [7:0] cap);
    cap = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi_i = b[i];
      wait_clk(8);
      sck_i = 1'b1;
      cap = {cap[6:0], miso_o};
      wait_clk(8);
      sck_i = 1'b0;
    end
    wait_clk(8);
  endtask

  task automatic test_slave();
    logic [7:0] v, cap;
    bus_write(2'd0, 8'h01);
    bus_write(2'd2, 8'h96);
    ss_n = 1'b0;
    wait_clk(8);
    check("R7 miso enabled while selected", miso_oe, 1);
    slave_bits(8'h4D, 8, cap);
    ss_n = 1'b1;
    wait_clk(6);
    check("R7 miso released when deselected", miso_oe, 0);
    check("R7 slave output bits", cap, 8'h96);
    bus_read(2'd1, v); check("R7 slave done flag", v, 8'h80);
    bus_read(2'd2, v); check("R7 slave received byte", v, 8'h4D);
    bus_read(2'd1, v); check("R6 slave flag cleared", v, 8'h00);
  endtask

  task automatic test_sserr();
    logic [7:0] v, cap;
    bus_write(2'd0, 8'h01);
    ss_n = 1'b0;
    wait_clk(8);
    slave_bits(8'hB2, 3, cap);
    ss_n = 1'b1;
    wait_clk(6);
    bus_read(2'd1, v); check("R8 select error, no done", v, 8'h20);
    bus_read(2'd2, v);
    bus_read(2'd1, v); check("R8 sequence does not clear select error", v, 8'h20);
    bus_write(2'd0, 8'h00);
    bus_read(2'd1, v); check("R8 disable clears select error", v, 8'h00);
    bus_write(2'd0, 8'h01);
    bus_read(2'd1, v); check("R8 stays clear after re-enable", v, 8'h00);
    bus_write(2'd0, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    test_reset();
    test_ctrl_map();
    test_disabled();
    test_master(1, 8'hA5, 8'h3C);
    test_master(3, 8'h81, 8'h7E);
    test_master(6, 8'h5B, 8'hC6);
    test_invalid_rate(8'h03);
    test_invalid_rate(8'h1F);
    test_wcol();
    test_no_premature_clear();
    test_modf();
    test_slave();
    test_sserr();
    summary();
  end
endmodule